// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives a three-wire serial EEPROM from the host side. A command port takes an operation code, an address, write data, a read burst length and a width mode flag. The block then builds the serial frame and drives chip select, a shift clock divided down from the system clock, and serial data toward the memory. On reads it collects the returned bits into words. After any operation that programs the array, it waits for the memory to report that it is ready.

Each frame opens with a start bit, then a two-bit opcode and the address, most significant bit first. Writes append their data after the address. Control commands carry a two-bit code in the top two address bits. A read returns `cmd_len + 1` consecutive words on one chip-select window, and the controller drops the single dummy bit that comes before the first word. A program operation ends its frame by dropping chip select for a minimum time. The controller then raises chip select again with the shift clock idle and samples serial data out until it reads 1. A limit counter ends a wait that lasts too long and reports an error.

Top module: `eeprom3w_host`

## Requirements
- R1: `cmd_ready` is high only while the block is idle, and chip select is low at that time. A command is taken when `cmd_valid` and `cmd_ready` are both high. Every command ends with `done` high for exactly one cycle.
- R2: `cmd_op` selects the operation: 0 read, 1 write, 2 erase, 3 program enable, 4 program disable, 5 erase all, 6 write all. A frame sends a start bit of 1 and then an opcode: read 10, write 01, erase 11, all other operations 00. The address follows MSB first. It is 11 bits when `cmd_word` is 0 (8-bit words) and 10 bits (`cmd_addr[9:0]`) when `cmd_word` is 1 (16-bit words).
- R3: Operations 3 to 6 put a code in the top two address bits and zeros in the rest. The codes are enable 11, erase all 10, write all 01, disable 00. After a disable, a write leaves the memory unchanged.
- R4: Write and write all send the data right after the address, MSB first: `cmd_wdata[7:0]` in 8-bit mode and `cmd_wdata[15:0]` in 16-bit mode.
- R5: A read discards the first bit returned after the address. It then returns `cmd_len + 1` words, one `rd_valid` pulse each, with no dummy bit between words. In 8-bit mode `rd_data[15:8]` is zero.
- R6: Every shift-clock high phase lasts exactly `CLK_DIV` clock cycles, and every low phase lasts at least that long. Serial data in does not change while the shift clock is high. The shift clock is high only while chip select is high.
- R7: Read data is sampled on the falling shift-clock edge.
- R8: After write, erase, erase all or write all, the block drops chip select for `CS_LOW_CYCLES` cycles. It then raises chip select once with the shift clock idle and samples data out every `CLK_DIV` cycles until it sees 1.
- R9: If ready is not seen within `BUSY_LIMIT` cycles of the frame end, `err` is high together with `done`.
- R10: Chip select stays low for at least `CS_LOW_CYCLES` cycles between any two high periods.
- R11: Read, enable and disable finish without a status poll, using one chip-select high period only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 11 | Word address |
| cmd_wdata | input | 16 | Write data |
| cmd_len | input | LEN_W | Read words minus one |
| cmd_word | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| rd_data | output | 16 | Returned read word |
| rd_valid | output | 1 | `rd_data` valid strobe |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Ready wait timed out (with `done`) |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data to memory |
| ee_do | input | 1 | Serial data from memory |

## Verification
The bench targets several edge cases and what a faulty design would show:
- Dummy bit on bursts: a design that skipped the dummy bit before every word, or none, would return words shifted by one bit. The bench checks a burst that wraps past the top of the address space.
- Code placement: placing the control code in the wrong address bits between the 11-bit and 10-bit layouts would send a frame that the bit-level sniffer rejects. A model that then never enables writes would read back stale data.
- Timeout: a memory that never reports ready must end with `err`, not hang.
- Disable: a disable followed by a write must leave the cell unchanged.
- Shift-clock edge: sampling on the rising edge would capture bits one position early.

// File: rtl/eeprom3w_host.sv
module eeprom3w_host #(
  parameter int CLK_DIV       = 32,
  parameter int CS_LOW_CYCLES = 32,
  parameter int BUSY_LIMIT    = 1250000,
  parameter int LEN_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [10:0]      cmd_addr,
  input  logic [15:0]      cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_word,
  output logic [15:0]      rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int CW = $clog2(CS_LOW_CYCLES + 1);
  localparam int TW = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_RECV, S_GAP, S_POLL, S_END} st_t;
  st_t st;

  logic [DW-1:0]    div;
  logic [CW-1:0]    gap;
  logic [TW-1:0]    tmo;
  logic [29:0]      frm;
  logic [4:0]       nb;
  logic [3:0]       rbit;
  logic [15:0]      rx;
  logic [LEN_W-1:0] left;
  logic             word_m, is_rd, prog_q, tout;

  logic [1:0]  opc, code;
  logic        special, has_data, is_prog;
  logic [29:0] frm_new;
  logic [4:0]  nb_new;

  always_comb begin
    case (cmd_op)
      3'd0:    opc = 2'b10;
      3'd1:    opc = 2'b01;
      3'd2:    opc = 2'b11;
      default: opc = 2'b00;
    endcase
    case (cmd_op)
      3'd3:    code = 2'b11;
      3'd5:    code = 2'b10;
      3'd6:    code = 2'b01;
      default: code = 2'b00;
    endcase
  end

  assign special  = cmd_op >= 3'd3;
  assign has_data = (cmd_op == 3'd1) || (cmd_op == 3'd6);
  assign is_prog  = (cmd_op == 3'd1) || (cmd_op == 3'd2) || (cmd_op == 3'd5) || (cmd_op == 3'd6);
  assign frm_new  = cmd_word
    ? {1'b1, opc, (special ? {code, 8'b0} : cmd_addr[9:0]), cmd_wdata, 1'b0}
    : {1'b1, opc, (special ? {code, 9'b0} : cmd_addr), cmd_wdata[7:0], 8'b0};
  assign nb_new   = (cmd_word ? 5'd13 : 5'd14) + (has_data ? (cmd_word ? 5'd16 : 5'd8) : 5'd0);

  wire tick = div == DW'(CLK_DIV - 1);
  wire run  = (st == S_SEND) || (st == S_RECV) || (st == S_POLL);
  wire [15:0] rx_next = {rx[14:0], ee_do};

  assign cmd_ready = st == S_IDLE;
  assign ee_cs     = (st != S_IDLE) && !((st == S_GAP) || (st == S_END));
  assign ee_di     = (st == S_SEND) & frm[29];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; gap <= '0; tmo <= '0; frm <= '0; nb <= '0;
      rbit <= '0; rx <= '0; left <= '0; word_m <= 1'b0; is_rd <= 1'b0;
      prog_q <= 1'b0; tout <= 1'b0; ee_sk <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      div      <= (run && !tick) ? div + 1'b1 : '0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          frm <= frm_new; nb <= nb_new; word_m <= cmd_word;
          is_rd <= cmd_op == 3'd0; prog_q <= is_prog; left <= cmd_len;
          rbit <= '0; rx <= '0; tout <= 1'b0; st <= S_SEND;
        end
        S_SEND: if (tick) begin
          ee_sk <= !ee_sk;
          if (ee_sk) begin
            if (nb != 5'd1) begin
              frm <= frm << 1;
              nb  <= nb - 1'b1;
            end else begin
              gap <= '0;
              tmo <= '0;
              st  <= is_rd ? S_RECV : (prog_q ? S_GAP : S_END);
            end
          end
        end
        S_RECV: if (tick) begin
          ee_sk <= !ee_sk;
          if (ee_sk) begin
            if (rbit == (word_m ? 4'd15 : 4'd7)) begin
              rd_data <= rx_next; rd_valid <= 1'b1; rx <= '0; rbit <= '0;
              if (left == '0) st <= S_END;
              else left <= left - 1'b1;
            end else begin
              rx <= rx_next; rbit <= rbit + 1'b1;
            end
          end
        end
        S_GAP: begin
          gap <= gap + 1'b1;
          tmo <= tmo + 1'b1;
          if (gap == CW'(CS_LOW_CYCLES - 1)) st <= S_POLL;
        end
        S_POLL: begin
          tmo <= tmo + 1'b1;
          if (tick && ee_do) begin
            gap <= '0; st <= S_END;
          end else if (tmo >= TW'(BUSY_LIMIT - 1)) begin
            tout <= 1'b1; gap <= '0; st <= S_END;
          end
        end
        S_END: begin
          gap <= gap + 1'b1;
          if (gap == CW'(CS_LOW_CYCLES - 1)) begin
            st <= S_IDLE; done <= 1'b1; err <= tout;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom3w_host_chk.sv
module eeprom3w_host_chk #(
  parameter int CLK_DIV       = 32,
  parameter int CS_LOW_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic done,
  input logic err,
  input logic rd_valid,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  logic [31:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= 32'(CS_LOW_CYCLES);
    end else begin
      hi_cnt <= ee_sk ? hi_cnt + 1 : '0;
      lo_cnt <= ee_cs ? '0 : ((lo_cnt < 32'(CS_LOW_CYCLES)) ? lo_cnt + 1 : lo_cnt);
    end
  end

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !ee_cs);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r6_sk_in_cs:   assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
  a_r6_di_stable:  assert property (@(posedge clk) disable iff (!rst_n) (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  a_r6_sk_high:    assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_sk) |-> hi_cnt == 32'(CLK_DIV));
  a_r9_err_done:   assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  a_r10_cs_gap:    assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> lo_cnt >= 32'(CS_LOW_CYCLES));
  a_r5_rd_in_cs:   assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(ee_cs));
endmodule

bind eeprom3w_host eeprom3w_host_chk #(.CLK_DIV(CLK_DIV), .CS_LOW_CYCLES(CS_LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .err(err),
  .rd_valid(rd_valid), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/eeprom3w_host_test.sv
module eeprom3w_host_test;
  localparam int CDIV = 4, CSL = 6, BLIM = 3000, MBUSY = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_word = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [7:0] cmd_len = '0;
  logic cmd_ready, rd_valid, done, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  eeprom3w_host #(.CLK_DIV(CDIV), .CS_LOW_CYCLES(CSL), .BUSY_LIMIT(BLIM), .LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len), .cmd_word(cmd_word),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [0:2047];
  logic m_en = 0, m_rd = 0, m_stat = 0, m_prog = 0, stuck = 0, m_do = 0;
  int m_cnt = 0, m_busy = 0, m_idx = 0, m_op = 0, m_code = 0;
  logic [31:0] m_sh = 0;
  logic [10:0] m_ra = 0, m_wa = 0;
  logic [15:0] m_rw = 0;

  assign ee_do = ee_cs & (m_rd ? m_do : (m_stat & (m_busy == 0)));

  initial for (int i = 0; i < 2048; i++) mem[i] = '0;

  task automatic m_program(input int kind, input logic [10:0] a, input logic [15:0] d);
    logic [15:0] dm;
    dm = cmd_word ? d : {8'h00, d[7:0]};
    m_prog = 1;
    if (m_en) begin
      m_busy = MBUSY;
      if (kind == 0) mem[a] = dm;
      else for (int i = 0; i < 2048; i++) mem[i] = dm;
    end
  endtask

  always @(posedge ee_cs) begin m_cnt = 0; m_rd = 0; m_sh = 0; end
  always @(negedge ee_cs) begin m_stat = m_prog; m_prog = 0; m_rd = 0; end
  always @(posedge clk) if (m_busy > 0 && !stuck) m_busy = m_busy - 1;

  always @(posedge ee_sk) if (ee_cs) begin
    int ab, db;
    logic [10:0] amask;
    ab = cmd_word ? 10 : 11;
    db = cmd_word ? 16 : 8;
    amask = cmd_word ? 11'h3FF : 11'h7FF;
    if (m_rd) begin
      if (m_idx == 0) begin
        m_rw = mem[m_ra];
        m_ra = (m_ra + 11'd1) & amask;
      end
      m_do = m_rw[db - 1 - m_idx];
      m_idx = (m_idx == db - 1) ? 0 : m_idx + 1;
    end else begin
      m_sh = {m_sh[30:0], ee_di};
      m_cnt++;
      if (m_cnt == 3 + ab) begin
        m_op = int'((m_sh >> ab) & 32'd3);
        m_wa = 11'(m_sh) & amask;
        m_code = int'(m_wa >> (ab - 2));
        if (m_op == 2) begin m_rd = 1; m_ra = m_wa; m_idx = 0; m_do = 0; end
        else if (m_op == 3) m_program(0, m_wa, 16'hFFFF);
        else if (m_op == 0 && m_code == 3) m_en = 1;
        else if (m_op == 0 && m_code == 0) m_en = 0;
        else if (m_op == 0 && m_code == 2) m_program(1, 11'd0, 16'hFFFF);
      end
      if (m_cnt == 3 + ab + db) begin
        if (m_op == 1) m_program(0, m_wa, 16'(m_sh));
        else if (m_op == 0 && m_code == 1) m_program(1, 11'd0, 16'(m_sh));
      end
    end
  end

  // ---------------- monitors ----------------
  int cs_rises = 0, done_cnt = 0, rd_n = 0;
  logic [15:0] rd_buf [0:63];
  logic cs_p = 0, sk_p = 0, di_p = 0;
  int hi_run = 0, lo_run = 1000, hi_min = 1000, hi_max = 0, cs_gap_min = 1000, di_viol = 0;

  always @(negedge clk) begin
    if (ee_cs && !cs_p) begin
      cs_rises++;
      if (lo_run < cs_gap_min) cs_gap_min = lo_run;
    end
    lo_run = ee_cs ? 0 : lo_run + 1;
    if (!ee_sk && sk_p) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
    end
    hi_run = ee_sk ? hi_run + 1 : 0;
    if (ee_sk && sk_p && ee_di != di_p) di_viol++;
    if (done) done_cnt++;
    if (rd_valid) begin rd_buf[rd_n % 64] = rd_data; rd_n++; end
    cs_p = ee_cs; sk_p = ee_sk; di_p = ee_di;
  end

  logic [31:0] fr = 0, exp_fr = 0;
  int fbits = 0, exp_n = 0;
  logic fr_clr = 0;
  always @(posedge ee_cs) fr_clr = 1;
  always @(posedge ee_sk) begin
    if (fr_clr) begin fr = 0; fbits = 0; fr_clr = 0; end
    if (fbits < exp_n) begin fr = {fr[30:0], ee_di}; fbits++; end
  end

  // ---------------- command helpers ----------------
  int c_rises, c_done, c_words, c_base;
  logic c_err;

  task automatic make_frame(input int op, input logic [10:0] a, input logic [15:0] d, input logic wm);
    int ab, db;
    logic [31:0] v;
    logic [1:0] oc, cd;
    ab = wm ? 10 : 11;
    db = wm ? 16 : 8;
    oc = (op == 0) ? 2'b10 : (op == 1) ? 2'b01 : (op == 2) ? 2'b11 : 2'b00;
    cd = (op == 3) ? 2'b11 : (op == 5) ? 2'b10 : (op == 6) ? 2'b01 : 2'b00;
    v = {29'd0, 1'b1, oc};
    v = (v << ab) | ((op >= 3) ? (32'(cd) << (ab - 2)) : (32'(a) & ((32'd1 << ab) - 1)));
    exp_n = 3 + ab;
    if (op == 1 || op == 6) begin
      v = (v << db) | (32'(d) & ((32'd1 << db) - 1));
      exp_n = exp_n + db;
    end
    exp_fr = v;
  endtask

  task automatic run_cmd(input int op, input logic [10:0] a, input logic [15:0] d,
                         input logic [7:0] len, input logic wm);
    int base_r, base_d, g;
    make_frame(op, a, d, wm);
    @(negedge clk);
    base_r = cs_rises; base_d = done_cnt; c_base = rd_n;
    cmd_op = 3'(op); cmd_addr = a; cmd_wdata = d; cmd_len = len; cmd_word = wm; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    g = 0;
    while (!done && g < 20000) begin @(negedge clk); g++; end
    c_err = err;
    check(g < 20000, "R1 done reached", 32'(g), 32'd0);
    repeat (2) @(negedge clk);
    c_rises = cs_rises - base_r; c_done = done_cnt - base_d; c_words = rd_n - c_base;
    check(c_done == 1, "R1 one done pulse", 32'(c_done), 32'd1);
    check(fr == exp_fr && fbits == exp_n, "R2/R3/R4 frame bits", fr, exp_fr);
  endtask

  task automatic t_enable(input logic wm);
    run_cmd(3, 11'h000, 16'h0, 8'd0, wm);
    check(c_rises == 1, "R11 enable single window", 32'(c_rises), 32'd1);
    check(!c_err, "R3 enable no error", 32'(c_err), 32'd0);
  endtask

  task automatic t_write(input int op, input logic [10:0] a, input logic [15:0] d, input logic wm);
    run_cmd(op, a, d, 8'd0, wm);
    check(c_rises == 2, "R8 program poll window", 32'(c_rises), 32'd2);
    check(!c_err, "R8 ready seen", 32'(c_err), 32'd0);
  endtask

  task automatic t_read(input logic [10:0] a, input logic [7:0] len, input logic wm,
                        input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2,
                        input string req);
    logic [15:0] ex [0:2];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    run_cmd(0, a, 16'h0, len, wm);
    check(c_rises == 1, "R11 read single window", 32'(c_rises), 32'd1);
    check(c_words == int'(len) + 1, "R5 word count", 32'(c_words), 32'(len) + 1);
    for (int i = 0; i <= int'(len) && i < 3; i++)
      check(rd_buf[(c_base + i) % 64] == ex[i], req, 32'(rd_buf[(c_base + i) % 64]), 32'(ex[i]));
  endtask

  task automatic t_timeout;
    t_enable(1'b0);
    stuck = 1;
    run_cmd(2, 11'h044, 16'h0, 8'd0, 1'b0);
    check(c_err == 1'b1, "R9 timeout err with done", 32'(c_err), 32'd1);
    check(c_rises == 2, "R9 poll window", 32'(c_rises), 32'd2);
    stuck = 0;
    repeat (MBUSY + 20) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready && !ee_cs && !ee_sk && !done, "R1 reset state",
          {28'd0, cmd_ready, ee_cs, ee_sk, done}, 32'h8);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // 8-bit mode
    t_enable(1'b0);
    t_write(1, 11'h123, 16'h00A5, 1'b0);
    t_read(11'h123, 8'd0, 1'b0, 16'h00A5, 16'h0, 16'h0, "R5 R7 byte read");
    t_write(1, 11'h7FE, 16'h0011, 1'b0);
    t_write(1, 11'h7FF, 16'h0022, 1'b0);
    t_write(1, 11'h000, 16'h0033, 1'b0);
    t_read(11'h7FE, 8'd2, 1'b0, 16'h0011, 16'h0022, 16'h0033, "R5 burst no dummy between words");
    t_write(2, 11'h123, 16'h0, 1'b0);
    t_read(11'h123, 8'd0, 1'b0, 16'h00FF, 16'h0, 16'h0, "R2 erase reads ones");
    t_write(6, 11'h000, 16'h773C, 1'b0);
    t_read(11'h010, 8'd1, 1'b0, 16'h003C, 16'h003C, 16'h0, "R3 R4 write all");
    t_write(5, 11'h000, 16'h0, 1'b0);
    t_read(11'h005, 8'd0, 1'b0, 16'h00FF, 16'h0, 16'h0, "R3 erase all");
    run_cmd(4, 11'h000, 16'h0, 8'd0, 1'b0);
    check(c_rises == 1, "R11 disable single window", 32'(c_rises), 32'd1);
    run_cmd(1, 11'h005, 16'h005A, 8'd0, 1'b0);
    t_read(11'h005, 8'd0, 1'b0, 16'h00FF, 16'h0, 16'h0, "R3 write ignored after disable");

    // 16-bit mode
    t_enable(1'b1);
    t_write(1, 11'h3FF, 16'hBEEF, 1'b1);
    t_write(1, 11'h000, 16'h1234, 1'b1);
    t_read(11'h3FF, 8'd1, 1'b1, 16'hBEEF, 16'h1234, 16'h0, "R2 R5 word mode burst");

    t_timeout();
    t_read(11'h000, 8'd0, 1'b0, 16'h0034, 16'h0, 16'h0, "R5 read after timeout, upper byte zero");

    check(hi_min == CDIV && hi_max == CDIV, "R6 shift clock high phase", 32'(hi_max), 32'(CDIV));
    check(di_viol == 0, "R6 data stable while clock high", 32'(di_viol), 32'd0);
    check(cs_gap_min >= CSL, "R10 chip select low gap", 32'(cs_gap_min), 32'(CSL));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule